// File: doc/BRIEF.md
# Change-Triggered Key Matrix Scanner

This block watches a 5-row by 6-column key matrix and starts to scan it only when a key is pressed or released. While it rests, every row line is held low, so any press pulls its column low and a release lets it go back high. After synchronisation, either kind of edge on a column wakes the scanner. The scanner then drives one row low at a time, samples the columns near the end of that row's slot, and builds a 30-bit picture of the matrix. It keeps cycling through the rows until a host sends a stop command.

After the first complete pass it raises an interrupt, which stays high until a stop arrives. If the picture changed during a later pass, the next stop does not halt the scan. Instead it restarts the pass sequence and drops the interrupt, so the host sees the new state before scanning can end. At any time the host can load the picture into a shift register and clock it out one bit per serial-clock strobe. The order runs row by row, column 0 first in each row.

Top module: `keymat_scanner`

## Requirements
- R1: After reset, `row_n` is all zeros, `irq` is 0 and `sdo` is 0. While idle, `row_n` stays all zeros and no scan starts unless a synchronised column changes level.
- R2: While idle, a high-to-low or low-to-high change on any `col_n` bit starts scanning within a few clock cycles.
- R3: While scanning, exactly one `row_n` bit is low. Rows are visited in the order 0,1,2,3,4 and then repeat, and each row is held for `ROW_TICKS` pulses of `tick`.
- R4: The columns are sampled on the last `tick` of each row slot. A low column (a pressed key) is stored as 1 at picture bit `row*6+col`.
- R5: `irq` goes high when the last row of the first complete pass is sampled. It stays high for as long as no stop command arrives.
- R6: When no change is pending, a one-cycle `stop_req` during scanning returns the block to idle with all rows low, and `irq` is 0 in the next cycle.
- R7: A one-cycle `out_req` loads the 30-bit picture. In the next cycle `sdo` shows bit 0 (row 0, column 0). Each `shift_stb` pulse advances `sdo` to the next higher bit, so the last bit is row 4, column 5.
- R8: If a sample taken in any pass after the first differs from the stored row, the next stop does not halt scanning. It clears `irq`, clears the pending flag and restarts at row 0, and `irq` rises again after one more complete pass. A later stop with no pending change then halts the scan.
- R9: A `stop_req` while idle has no effect: rows stay low and `irq` stays 0.
- R10: After the block returns to idle, column changes caused by the rows being released are ignored. With keys held through a stop, the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_n | input | 6 | Column return lines, low when a key on the driven row is pressed |
| tick | input | 1 | One-cycle bit-time pulse that paces the row slots |
| stop_req | input | 1 | One-cycle scan stop command |
| out_req | input | 1 | One-cycle request to load the picture into the output shifter |
| shift_stb | input | 1 | One-cycle pulse per rising serial-clock edge, advancing `sdo` |
| row_n | output | 5 | Row drive lines, low = driven |
| irq | output | 1 | Interrupt, high after the first complete pass |
| sdo | output | 1 | Serial picture data |

## Verification
The assertions assume that the command inputs are single-cycle pulses in the block's clock domain and that `tick` has at least a couple of clock cycles between pulses. Under that spacing the column synchronisers settle before a row's sample tick. The bench models the matrix as a wired AND of pressed keys on low rows, and it produces `tick` every second clock. Random key patterns are applied only from the all-released idle state, and the bench waits at least two full passes before it reads out or stops. Key changes therefore land in a later pass rather than on a sample edge.

// File: rtl/ks_pkg.sv
package ks_pkg;
    typedef enum logic {
        KS_IDLE = 1'b0,
        KS_SCAN = 1'b1
    } ks_state_e;
endpackage

// File: rtl/ks_colsync.sv
module ks_colsync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        stg_d[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
        prev_d = stg_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '1;
            end
            prev_q <= '1;
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
            prev_q <= prev_d;
        end
    end

    assign sync_o = stg_q[STAGES-1];
    assign prev_o = prev_q;
endmodule

// File: rtl/ks_scan_ctrl.sv
module ks_scan_ctrl
    import ks_pkg::*;
#(
    parameter int ROWS      = 5,
    parameter int COLS      = 6,
    parameter int ROW_TICKS = 64,
    parameter int SETTLE    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 stop_req,
    input  logic [COLS-1:0]      col_s,
    input  logic [COLS-1:0]      col_p,
    output logic [ROWS-1:0]      row_n,
    output logic                 irq,
    output logic                 scanning,
    output logic [ROWS*COLS-1:0] img
);
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int CNT_W = (ROW_TICKS > 1) ? $clog2(ROW_TICKS) : 1;
    localparam int SET_W = $clog2(SETTLE + 1);
    localparam int NBITS = ROWS * COLS;
    localparam logic [ROW_W-1:0] LAST_ROW  = ROW_W'(ROWS - 1);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(ROW_TICKS - 1);

    typedef struct packed {
        ks_state_e        state;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] cnt;
        logic             first_done;
        logic             chg;
        logic             irq;
        logic [SET_W-1:0] settle;
        logic [NBITS-1:0] img;
    } ctrl_t;

    ctrl_t q, d;
    logic [COLS-1:0] sample;

    always_comb begin
        d      = q;
        sample = ~col_s;
        if (q.settle != '0) begin
            d.settle = q.settle - 1'b1;
        end
        case (q.state)
            KS_IDLE: begin
                if (q.settle == '0 && col_s != col_p) begin
                    d.state      = KS_SCAN;
                    d.row        = '0;
                    d.cnt        = '0;
                    d.first_done = 1'b0;
                    d.chg        = 1'b0;
                end
            end
            default: begin
                if (stop_req) begin
                    d.irq = 1'b0;
                    if (q.chg) begin
                        d.row        = '0;
                        d.cnt        = '0;
                        d.first_done = 1'b0;
                        d.chg        = 1'b0;
                    end else begin
                        d.state  = KS_IDLE;
                        d.settle = SET_W'(SETTLE);
                    end
                end else if (tick) begin
                    if (q.cnt == LAST_TICK) begin
                        d.cnt = '0;
                        if (q.first_done &&
                            sample != q.img[q.row*COLS +: COLS]) begin
                            d.chg = 1'b1;
                        end
                        d.img[q.row*COLS +: COLS] = sample;
                        if (q.row == LAST_ROW) begin
                            d.row        = '0;
                            d.first_done = 1'b1;
                            d.irq        = 1'b1;
                        end else begin
                            d.row = q.row + 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: KS_IDLE, row: '0, cnt: '0, first_done: 1'b0,
                   chg: 1'b0, irq: 1'b0, settle: '0, img: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        row_n = '0;
        if (q.state == KS_SCAN) begin
            row_n = ~(ROWS'(1) << q.row);
        end
    end

    assign irq      = q.irq;
    assign scanning = (q.state == KS_SCAN);
    assign img      = q.img;

    AST_IDLE_ROWS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !scanning |-> row_n == '0); // R1
    AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!scanning && q.settle == '0 && col_s != col_p) |=> scanning); // R2
    AST_ONE_ROW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        scanning |-> $countones(row_n) == ROWS - 1); // R3
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stop_req) |=> irq); // R5
    AST_IRQ_NEEDS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> scanning); // R5
    AST_STOP_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !irq); // R6
    AST_IDLE_STOP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!scanning && stop_req && col_s == col_p) |=> !scanning); // R9
endmodule

// File: rtl/ks_shift.sv
module ks_shift #(
    parameter int N = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] data,
    input  logic         shift_stb,
    output logic         sdo
);
    logic [N-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load) begin
            sr_d = data;
        end else if (shift_stb) begin
            sr_d = {1'b0, sr_q[N-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign sdo = sr_q[0];

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_stb && !load) |=> sdo == $past(sr_q[1])); // R7
endmodule

// File: rtl/keymat_scanner.sv
module keymat_scanner #(
    parameter int ROWS        = 5,
    parameter int COLS        = 6,
    parameter int ROW_TICKS   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [COLS-1:0] col_n,
    input  logic            tick,
    input  logic            stop_req,
    input  logic            out_req,
    input  logic            shift_stb,
    output logic [ROWS-1:0] row_n,
    output logic            irq,
    output logic            sdo
);
    localparam int NBITS  = ROWS * COLS;
    localparam int SETTLE = SYNC_STAGES + 2;

    logic [COLS-1:0]  col_s, col_p;
    logic [NBITS-1:0] img;
    logic             scanning;

    ks_colsync #(.W(COLS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (col_n),
        .sync_o (col_s),
        .prev_o (col_p)
    );

    ks_scan_ctrl #(
        .ROWS(ROWS), .COLS(COLS), .ROW_TICKS(ROW_TICKS), .SETTLE(SETTLE)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .stop_req (stop_req),
        .col_s    (col_s),
        .col_p    (col_p),
        .row_n    (row_n),
        .irq      (irq),
        .scanning (scanning),
        .img      (img)
    );

    ks_shift #(.N(NBITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (out_req),
        .data      (img),
        .shift_stb (shift_stb),
        .sdo       (sdo)
    );

    AST_LOAD_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_req |=> sdo == $past(img[0])); // R7
endmodule

// File: tb/keymat_scanner_bench.sv
module keymat_scanner_bench;
    localparam int ROWS = 5, COLS = 6, RT = 64, TDIV = 2;
    localparam int NB = ROWS * COLS;
    localparam int PASS_CLK = ROWS * RT * TDIV;

    logic clk = 0, rst_n = 0;
    logic [COLS-1:0] col_n;
    logic tick = 0, stop_req = 0, out_req = 0, shift_stb = 0;
    logic [ROWS-1:0] row_n;
    logic irq, sdo;
    logic [NB-1:0] keys = '0;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit lenchk = 0;

    always #10 clk = ~clk;

    keymat_scanner u_keymat_scanner (
        .clk(clk), .rst_n(rst_n), .col_n(col_n), .tick(tick),
        .stop_req(stop_req), .out_req(out_req), .shift_stb(shift_stb),
        .row_n(row_n), .irq(irq), .sdo(sdo)
    );

    // matrix model: a pressed key ties its column to its row line
    always_comb begin
        for (int c = 0; c < COLS; c++) begin
            col_n[c] = 1'b1;
            for (int r = 0; r < ROWS; r++) begin
                if (keys[r*COLS+c] && !row_n[r]) col_n[c] = 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        tick <= (cyc % TDIV == 0);
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act=%0d exp<=150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int active_row(input logic [ROWS-1:0] r);
        for (int i = 0; i < ROWS; i++) if (!r[i]) return i;
        return -1;
    endfunction

    // R3 order/length monitor
    int prev_row = -1, run_len = 0;
    bit run_full = 0;
    always @(negedge clk) begin
        if (rst_n && row_n != '0) begin
            int a;
            a = active_row(row_n);
            if (a != prev_row) begin
                if (prev_row >= 0) begin
                    chk(a == (prev_row + 1) % ROWS || a == 0, "R3 row order", a, (prev_row + 1) % ROWS);
                    if (lenchk && run_full)
                        chk(run_len == RT * TDIV, "R3 row length", run_len, RT * TDIV);
                    run_full = 1;
                end
                prev_row = a; run_len = 1;
            end else run_len++;
        end else begin
            prev_row = -1; run_full = 0; run_len = 0;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_req = 1;
        @(negedge clk) stop_req = 0;
    endtask

    task automatic read_image(output logic [NB-1:0] got);
        @(negedge clk) out_req = 1;
        @(negedge clk) out_req = 0;
        for (int i = 0; i < NB; i++) begin
            got[i] = sdo;
            shift_stb = (i < NB - 1);
            @(negedge clk);
        end
        shift_stb = 0;
    endtask

    task automatic wait_irq(input string tag);
        int k = 0;
        while (!irq && k < 2 * PASS_CLK) begin @(negedge clk); k++; end
        chk(irq == 1'b1, tag, irq, 1);
    endtask

    logic [NB-1:0] got;

    initial begin
        void'($urandom(32'h5EED_1234));
        wait_clk(3);
        rst_n = 1;
        wait_clk(2);
        // R1 reset state
        chk(row_n == '0, "R1 reset rows", row_n, 0);
        chk(irq == 0, "R1 reset irq", irq, 0);
        chk(sdo == 0, "R1 reset sdo", sdo, 0);
        wait_clk(200);
        chk(row_n == '0, "R1 idle without change", row_n, 0);

        // R2 press starts scan; R3 timing; R5 irq after first pass
        lenchk = 1;
        keys[2*COLS+3] = 1;
        wait_clk(8);
        chk(row_n != '0, "R2 press starts scan", row_n, 32'h1e);
        wait_clk(PASS_CLK / 2);
        chk(irq == 0, "R5 irq low mid first pass", irq, 0);
        wait_irq("R5 irq after first pass");
        wait_clk(3 * PASS_CLK);
        chk(irq == 1, "R5 irq holds", irq, 1);
        lenchk = 0;

        // R4/R7 readout
        read_image(got);
        chk(got == keys, "R4 R7 picture readout", got, keys);

        // R8 change during later pass -> first stop ignored
        keys[4*COLS+0] = 1;
        wait_clk(2 * PASS_CLK + 10);
        pulse_stop();
        wait_clk(10);
        chk(row_n != '0, "R8 stop ignored keeps scanning", row_n, 32'h1e);
        chk(irq == 0, "R8 ignored stop clears irq", irq, 0);
        wait_irq("R8 irq again after restart");
        read_image(got);
        chk(got == keys, "R8 picture after change", got, keys);
        pulse_stop();
        wait_clk(10);
        chk(row_n == '0, "R6 second stop halts", row_n, 0);
        chk(irq == 0, "R6 irq low after stop", irq, 0);

        // R10 keys held through stop: stays idle
        wait_clk(300);
        chk(row_n == '0, "R10 no spurious restart", row_n, 0);

        // R9 stop while idle
        pulse_stop();
        wait_clk(20);
        chk(row_n == '0 && irq == 0, "R9 idle stop inert", {row_n, irq}, 0);

        // R2 release starts scan; R6 stop in first pass halts
        keys = '0;
        wait_clk(8);
        chk(row_n != '0, "R2 release starts scan", row_n, 32'h1e);
        wait_clk(50);
        pulse_stop();
        wait_clk(10);
        chk(row_n == '0, "R6 early stop halts", row_n, 0);

        // random patterns from released idle
        for (int it = 0; it < 8; it++) begin
            logic [NB-1:0] pat;
            pat = NB'($urandom) | (NB'(1) << ($urandom % NB));
            wait_clk(20);
            keys = pat;
            wait_clk(8);
            chk(row_n != '0, "R2 random start", row_n, 32'h1e);
            wait_clk(2 * PASS_CLK + 20);
            chk(irq == 1, "R5 random irq", irq, 1);
            read_image(got);
            chk(got == pat, "R4 R7 random picture", got, pat);
            keys = '0;
            wait_clk(2 * PASS_CLK + 20);
            pulse_stop();
            wait_clk(10);
            chk(row_n != '0 && irq == 0, "R8 random stop ignored", {row_n, irq}, 32'h3c);
            wait_irq("R8 random irq again");
            read_image(got);
            chk(got == '0, "R4 random released picture", got, 0);
            pulse_stop();
            wait_clk(10);
            chk(row_n == '0 && irq == 0, "R6 random halt", {row_n, irq}, 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule